// File: doc/BRIEF.md
# Level-Dependent Three-Sequence Dither Generator

This block drives the calibration dither of one quasi-2-bit pipeline stage. It runs three independent pseudo-random binary sequences, each read as +1 or -1, and adds them into a signed sum of -3, -1, +1 or +3. For every sample it also picks a dither amplitude. The choice depends on that sum and on where the stage input sits inside its coarse comparator level.

The stage has five coarse levels, separated by main thresholds at ±0.2 and ±0.6 of the reference. Two further comparators split each coarse level into a low, a middle and a high sub-level. Near the lower edge of a level, only positive dither is allowed to be large. Near the upper edge, only negative dither is. This lets the average dither be larger while the residue stays inside a fixed 0.2-reference redundancy.

The amplitude is given in units of 1/30 of the reference, so every table value is an exact integer. The sequence bits, the sum, the amplitude and the signed dither word are all registered together. The analog dither DAC and the digital correction logic therefore see values from the same sample.

Top module: `dith_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all three sequence generators reload an all-ones seed. After that edge `pn_bits` = 3'b000, `pn_sum` = -3, `amp_code` = 0 and `dither` = 0.
- R2: Sequence i is a left-shifting Fibonacci LFSR. Generator 0 is 7 bits wide with feedback bit6^bit5. Generator 1 is 9 bits wide with feedback bit8^bit4. Generator 2 is 11 bits wide with feedback bit10^bit8. The feedback enters at bit 0. Each generator shifts once per edge at which `en` is high, and its MSB before the shift is presented as `pn_bits[i]`.
- R3: A `pn_bits` bit of 1 means +1 and a bit of 0 means -1. `pn_sum` is the 3-bit two's-complement sum, equal to 2·(number of ones) − 3.
- R4: `sub_lvl` 0, 1 and 2 select the low, middle and high sub-level. `amp_code` (in units of ref/30) is:
  - sum -3: 0, 3, 9
  - sum -1: 0, 1, 3
  - sum +1: 3, 1, 0
  - sum +3: 9, 3, 0
  
  The coarse level (`coarse_lvl` 0 to 4) does not change the amplitude.
- R5: `dither` is the 6-bit two's-complement product `pn_sum`·`amp_code`. It is never negative for a low sub-level sample and never positive for a high sub-level sample.
- R6: A sample with `coarse_lvl` > 4 or `sub_lvl` = 3 gives `amp_code` = 0 and `dither` = 0. The sequences still advance and their bits are still presented.
- R7: At an edge with `en` low, all outputs and all generator states hold. The next enabled sample continues the sequences where they stopped.
- R8: The inputs sampled at an enabled edge and the sequence bits used for that sample appear together on all outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sample enable; advances the sequences and loads the outputs |
| coarse_lvl | input | 3 | Coarse comparator level, 0 (lowest) to 4 |
| sub_lvl | input | 2 | Sub-level within the coarse level, 0 low, 1 middle, 2 high |
| pn_bits | output | 3 | Registered sequence bits, 1 means +1 |
| pn_sum | output | 3 | Signed sum of the three sequence values |
| amp_code | output | 4 | Dither amplitude in units of ref/30 |
| dither | output | 6 | Signed dither word, pn_sum times amp_code |

## Verification
A vector table walks all fifteen legal coarse/sub-level pairs, plus illegal codes and enable gaps. Each sample is compared with a reference model of the three generators, so a wrong tap, seed or bit order shows up as a diverging sequence. A long sweep lets each of the four sum values meet each sub-level many times. This separates an amplitude table that is mirrored, or that is indexed by the wrong sub-level, from the correct one. Disabled stretches with changing inputs show that nothing moves when it should not. A reset in the middle of a run shows that the sequences restart from the seed.

// File: rtl/dith_pkg.sv
package dith_pkg;

    localparam int NUM_PN    = 3;
    localparam int CLVL_W    = 3;
    localparam int SLVL_W    = 2;
    localparam int NUM_CLVL  = 5;
    localparam int NUM_SLVL  = 3;
    localparam int CNT_W     = $clog2(NUM_PN + 1);
    localparam int SUM_W     = CNT_W + 1;
    localparam int AMP_W     = 4;
    localparam int DITH_W    = SUM_W + AMP_W - 1;
    localparam int TAP_MAX_W = 16;

    // amplitudes in units of ref/30
    localparam logic [AMP_W-1:0] AMP_NONE  = 4'd0;
    localparam logic [AMP_W-1:0] AMP_SMALL = 4'd1;
    localparam logic [AMP_W-1:0] AMP_MED   = 4'd3;
    localparam logic [AMP_W-1:0] AMP_LARGE = 4'd9;

    typedef enum logic [SLVL_W-1:0] {
        SUB_LO  = 2'd0,
        SUB_MID = 2'd1,
        SUB_HI  = 2'd2
    } sub_lvl_e;

    typedef struct packed {
        logic [NUM_PN-1:0]        pn;
        logic signed [SUM_W-1:0]  sum;
        logic [AMP_W-1:0]         amp;
        logic signed [DITH_W-1:0] dith;
    } dith_word_t;

    function automatic int lfsr_width(input int idx);
        case (idx)
            0:       return 7;
            1:       return 9;
            default: return 11;
        endcase
    endfunction

    function automatic logic [TAP_MAX_W-1:0] lfsr_taps(input int idx);
        case (idx)
            0:       return 16'h0060;
            1:       return 16'h0110;
            default: return 16'h0500;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] count_ones(input logic [NUM_PN-1:0] b);
        logic [CNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < NUM_PN; i++) begin
            c = c + CNT_W'(b[i]);
        end
        return c;
    endfunction

    // ones: 0 -> sum -3, 1 -> -1, 2 -> +1, 3 -> +3
    function automatic logic [AMP_W-1:0] amp_of(input logic [CNT_W-1:0] ones,
                                                input logic [SLVL_W-1:0] sub);
        logic [AMP_W-1:0] a;
        a = AMP_NONE;
        case (ones)
            2'd0: case (sub)
                      SUB_MID: a = AMP_MED;
                      SUB_HI:  a = AMP_LARGE;
                      default: a = AMP_NONE;
                  endcase
            2'd1: case (sub)
                      SUB_MID: a = AMP_SMALL;
                      SUB_HI:  a = AMP_MED;
                      default: a = AMP_NONE;
                  endcase
            2'd2: case (sub)
                      SUB_LO:  a = AMP_MED;
                      SUB_MID: a = AMP_SMALL;
                      default: a = AMP_NONE;
                  endcase
            default: case (sub)
                      SUB_LO:  a = AMP_LARGE;
                      SUB_MID: a = AMP_MED;
                      default: a = AMP_NONE;
                  endcase
        endcase
        return a;
    endfunction

endpackage

// File: rtl/dith_lfsr.sv
module dith_lfsr #(
    parameter int               WIDTH = 7,
    parameter logic [WIDTH-1:0] TAPS  = 7'h60,
    parameter logic [WIDTH-1:0] SEED  = '1
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic bit_o
);

    logic [WIDTH-1:0] state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
        end else if (adv) begin
            state <= {state[WIDTH-2:0], ^(state & TAPS)};
        end
    end

    assign bit_o = state[WIDTH-1];

endmodule

// File: rtl/dith_amp_lut.sv
module dith_amp_lut
    import dith_pkg::*;
(
    input  logic [NUM_PN-1:0] pn_i,
    input  logic [CLVL_W-1:0] coarse_i,
    input  logic [SLVL_W-1:0] sub_i,
    output logic [AMP_W-1:0]  amp_o
);

    logic lvl_ok;

    always_comb begin
        lvl_ok = (coarse_i < CLVL_W'(NUM_CLVL)) && (sub_i < SLVL_W'(NUM_SLVL));
        amp_o  = lvl_ok ? amp_of(count_ones(pn_i), sub_i) : AMP_NONE;
    end

endmodule

// File: rtl/dith_out_stage.sv
module dith_out_stage
    import dith_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [NUM_PN-1:0] pn_i,
    input  logic [AMP_W-1:0]  amp_i,
    output dith_word_t        q
);

    localparam int PROD_W = 2 * DITH_W;

    dith_word_t              nxt;
    logic [SUM_W-1:0]        sum_raw;
    logic signed [PROD_W-1:0] s_ext;
    logic signed [PROD_W-1:0] a_ext;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        sum_raw  = {count_ones(pn_i), 1'b0} - SUM_W'(NUM_PN);
        s_ext    = PROD_W'($signed(sum_raw));
        a_ext    = $signed({{(PROD_W-AMP_W){1'b0}}, amp_i});
        prod     = s_ext * a_ext;
        nxt.pn   = pn_i;
        nxt.sum  = $signed(sum_raw);
        nxt.amp  = amp_i;
        nxt.dith = prod[DITH_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.pn   <= '0;
            q.sum  <= -SUM_W'(NUM_PN);
            q.amp  <= AMP_NONE;
            q.dith <= '0;
        end else if (load) begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/dith_gen.sv
module dith_gen
    import dith_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [CLVL_W-1:0]        coarse_lvl,
    input  logic [SLVL_W-1:0]        sub_lvl,
    output logic [NUM_PN-1:0]        pn_bits,
    output logic signed [SUM_W-1:0]  pn_sum,
    output logic [AMP_W-1:0]         amp_code,
    output logic signed [DITH_W-1:0] dither
);

    logic [NUM_PN-1:0] pn_now;
    logic [AMP_W-1:0]  amp_now;
    dith_word_t        word_q;

    for (genvar g = 0; g < NUM_PN; g++) begin : g_seq
        localparam int                   LW = lfsr_width(g);
        localparam logic [TAP_MAX_W-1:0] LT = lfsr_taps(g);
        dith_lfsr #(
            .WIDTH (LW),
            .TAPS  (LT[LW-1:0]),
            .SEED  ({LW{1'b1}})
        ) u_lfsr (
            .clk   (clk),
            .rst   (rst),
            .adv   (en),
            .bit_o (pn_now[g])
        );
    end

    dith_amp_lut u_lut (
        .pn_i     (pn_now),
        .coarse_i (coarse_lvl),
        .sub_i    (sub_lvl),
        .amp_o    (amp_now)
    );

    dith_out_stage u_out (
        .clk   (clk),
        .rst   (rst),
        .load  (en),
        .pn_i  (pn_now),
        .amp_i (amp_now),
        .q     (word_q)
    );

    assign pn_bits  = word_q.pn;
    assign pn_sum   = word_q.sum;
    assign amp_code = word_q.amp;
    assign dither   = word_q.dith;

endmodule

// File: rtl/dith_gen_chk.sv
module dith_gen_chk
    import dith_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     en,
    input logic [CLVL_W-1:0]        coarse_lvl,
    input logic [SLVL_W-1:0]        sub_lvl,
    input logic [NUM_PN-1:0]        pn_bits,
    input logic signed [SUM_W-1:0]  pn_sum,
    input logic [AMP_W-1:0]         amp_code,
    input logic signed [DITH_W-1:0] dither
);

    // R1
    rst_clears_chk: assert property (@(posedge clk)
        rst |=> (pn_bits == '0 && amp_code == '0 && dither == '0));

    // R3
    sum_bits_chk: assert property (@(posedge clk) disable iff (rst)
        int'(pn_sum) == 2 * $countones(pn_bits) - NUM_PN);

    // R4
    amp_legal_chk: assert property (@(posedge clk) disable iff (rst)
        amp_code inside {4'd0, 4'd1, 4'd3, 4'd9});

    // R5
    dither_prod_chk: assert property (@(posedge clk) disable iff (rst)
        int'(dither) == int'(pn_sum) * int'(amp_code));

    // R5
    low_sub_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (en && sub_lvl == 2'd0) |=> (dither >= 0));

    // R5
    high_sub_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (en && sub_lvl == 2'd2) |=> (dither <= 0));

    // R6
    bad_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        (en && (coarse_lvl > 3'd4 || sub_lvl == 2'd3)) |=> (amp_code == '0 && dither == '0));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(pn_bits) && $stable(amp_code) && $stable(dither)));

endmodule

bind dith_gen dith_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .coarse_lvl (coarse_lvl),
    .sub_lvl    (sub_lvl),
    .pn_bits    (pn_bits),
    .pn_sum     (pn_sum),
    .amp_code   (amp_code),
    .dither     (dither)
);

// File: tb/dith_gen_bench.sv
`timescale 1ns/1ps
module dith_gen_bench;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en  = 1'b0;
    logic [2:0]        coarse_lvl = '0;
    logic [1:0]        sub_lvl    = '0;
    logic [2:0]        pn_bits;
    logic signed [2:0] pn_sum;
    logic [3:0]        amp_code;
    logic signed [5:0] dither;

    int n_chk  = 0;
    int n_fail = 0;

    // reference generators
    logic [6:0]  m0;
    logic [8:0]  m1;
    logic [10:0] m2;
    int e_bits, e_sum, e_amp, e_dith;

    always #2.5 clk = ~clk;

    dith_gen u_dith_gen (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .coarse_lvl (coarse_lvl),
        .sub_lvl    (sub_lvl),
        .pn_bits    (pn_bits),
        .pn_sum     (pn_sum),
        .amp_code   (amp_code),
        .dither     (dither)
    );

    // {en, coarse[2:0], sub[1:0]}
    localparam logic [5:0] VEC [0:19] = '{
        6'b1_000_00, 6'b1_000_01, 6'b1_000_10, 6'b1_001_00, 6'b1_001_01,
        6'b1_001_10, 6'b1_010_00, 6'b1_010_01, 6'b1_010_10, 6'b0_011_01,
        6'b1_011_00, 6'b1_011_01, 6'b1_011_10, 6'b1_100_00, 6'b1_100_01,
        6'b1_100_10, 6'b1_101_01, 6'b1_010_11, 6'b0_111_10, 6'b1_111_11
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int amp_ref(input int s, input int sub);
        if (sub == 1) return (s == 3 || s == -3) ? 3 : 1;
        if (sub == 0) return (s == 3) ? 9 : (s == 1) ? 3 : 0;
        return (s == -3) ? 9 : (s == -1) ? 3 : 0;
    endfunction

    task automatic model_reset();
        m0 = '1; m1 = '1; m2 = '1;
        e_bits = 0; e_sum = -3; e_amp = 0; e_dith = 0;
    endtask

    task automatic check_all(input string tag_amp);
        chk("R2 pn_bits", int'(pn_bits), e_bits);
        chk("R3 pn_sum", int'(pn_sum), e_sum);
        chk(tag_amp, int'(amp_code), e_amp);
        chk("R5 dither", int'(dither), e_dith);
    endtask

    // called just after a falling edge; checks after the next one
    task automatic step(input logic e, input logic [2:0] c, input logic [1:0] s);
        int ones;
        en = e; coarse_lvl = c; sub_lvl = s;
        if (e) begin
            e_bits = {m2[10], m1[8], m0[6]};
            ones   = int'(m0[6]) + int'(m1[8]) + int'(m2[10]);
            e_sum  = 2 * ones - 3;
            e_amp  = (c < 5 && s < 3) ? amp_ref(e_sum, int'(s)) : 0;
            e_dith = e_sum * e_amp;
            m0 = {m0[5:0], m0[6] ^ m0[5]};
            m1 = {m1[7:0], m1[8] ^ m1[4]};
            m2 = {m2[9:0], m2[10] ^ m2[8]};
        end
        @(negedge clk);
        if (!e) check_all("R7 hold");
        else if (c > 4 || s > 2) check_all("R6 amp_zero");
        else check_all("R4 amp / R8 align");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        check_all("R1 reset");
        rst = 1'b0;

        // table walk
        for (int i = 0; i < 20; i++) begin
            step(VEC[i][5], VEC[i][4:2], VEC[i][1:0]);
        end

        // R7 long disabled stretch with moving inputs
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 3'(i % 5), 2'(i % 3));
        end

        // R2 R4 long sweep
        for (int i = 0; i < 300; i++) begin
            step(1'b1, 3'(i % 5), 2'((i / 5) % 3));
        end

        // R6 illegal codes keep the sequence moving
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 3'(5 + (i % 3)), 2'(3 - (i % 2) * 3));
        end
        step(1'b1, 3'd2, 2'd1);

        // R1 reset mid-run restarts from the seed
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_all("R1 mid reset");
        for (int i = 0; i < 30; i++) begin
            step(1'b1, 3'(i % 5), 2'(i % 3));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule